// File: doc/BRIEF.md
# Flush-token handshake port wrapper

This block surrounds a small compute unit with input and output ports that follow a four-phase request/acknowledge handshake. Every word on an input carries one extra bit above the data field. When that bit is set the word is a flush token rather than an operand. The wrapper hides tokens from the unit and acknowledges them itself. It also applies one rule across all input ports to decide when tokens and ordinary words are thrown away.

The default build has two inputs and one output. The unit adds its operands modulo 2^WIDTH. It fires when every input holds an ordinary word and the output is free. A token acts as a barrier. While one port holds a token, ordinary words arriving on the other ports are acknowledged and dropped. Once every port holds a token, all of the tokens are acknowledged together.

A sender raises its request with a word and waits for the acknowledge. It then lowers the request and waits for the acknowledge to fall before offering its next word. The consumer on the output side does the same in the opposite direction.

Top module: `hsf_port_wrap`

## Requirements
- R1: While reset is high, every input acknowledge reads 1, the output request reads 0 and the output data reads 0.
- R2: An input whose acknowledge is high while its request is low lowers that acknowledge at the next clock edge.
- R3: When every input request is high with data bit WIDTH clear, and the output request and output acknowledge are both low, the next edge does three things. It raises the output request, it sets output data bits WIDTH-1:0 to the sum of the inputs modulo 2^WIDTH with bit WIDTH equal to 0, and it raises every input acknowledge.
- R4: The output request and output data hold unchanged until the output acknowledge is seen high. The request falls at the edge after that.
- R5: No new result is produced while the output request or the output acknowledge is high.
- R6: A word with bit WIDTH set (a flush token) is never passed to the unit. It is never acknowledged unless the group rule applies.
- R7: When all inputs request at once, none is yet acknowledged, and every word is a token, all inputs are acknowledged at the next edge and no result is produced.
- R8: When all inputs request at once, none is yet acknowledged, and only some words are tokens, the ports holding ordinary words are acknowledged at the next edge and those words are dropped. The token ports stay unacknowledged.
- R9: An acknowledge given by the flush rule falls one edge after the sender lowers its request.
- R10: The flush rule takes no action while any input request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | N_IN | Request from each input sender |
| in_data | input | N_IN x (WIDTH+1) | Word on each input; bit WIDTH marks a flush token |
| in_ack | output | N_IN | Acknowledge to each input sender |
| out_req | output | 1 | Request to the output consumer |
| out_data | output | WIDTH+1 | Result word; bit WIDTH is always 0 |
| out_ack | input | 1 | Acknowledge from the output consumer |

## Verification
Several events can fall in the same cycle: the output handing its result to the consumer, input acknowledges being released, and flush flags clearing on ports whose senders have just let go. The bench provokes this mix by driving both senders and the consumer with random delays from a seeded generator, on word lists that scatter tokens among ordinary operands. The directed part of the bench does two more things. It holds fresh operands at the inputs while the output is still occupied, then releases the consumer and checks that the waiting operands fire exactly at the edge after the output becomes empty. Results are judged in order against a transaction-level model that resolves each round of list heads as a sum, a joint flush or a discard, and that also predicts how many words each port must see acknowledged.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_PORTS = 2;

    // outcome of the group flush rule in one cycle
    typedef enum logic [1:0] {
        FL_NONE = 2'd0,
        FL_ALL  = 2'd1,
        FL_SOME = 2'd2
    } flush_kind_e;

    // per-input view shared with the top level
    typedef struct packed {
        logic full;     // operand waiting, not yet taken
        logic ack_reg;  // unit-side acknowledge register
        logic flag;     // flush-side acknowledge flag
    } in_stat_t;

    // request the unit sees: a token never looks like a request
    function automatic logic seen_req(input logic raw, input logic mark);
        return raw & ~mark;
    endfunction

endpackage

// File: rtl/hsf_in_port.sv
module hsf_in_port
    import hsf_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_req,
    input  logic [WIDTH:0]   word,
    input  logic             fire,
    input  logic             flag_set,
    output logic             ack_out,
    output logic             marked,
    output logic [WIDTH-1:0] payload,
    output in_stat_t         stat
);

    logic ack_q;
    logic flag_q;
    logic req_seen;

    assign marked   = word[WIDTH];
    assign payload  = word[WIDTH-1:0];
    assign req_seen = seen_req(raw_req, marked);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            if (fire)
                ack_q <= 1'b1;
            else if (ack_q && !req_seen)
                ack_q <= 1'b0;

            if (!raw_req)
                flag_q <= 1'b0;
            else if (flag_set)
                flag_q <= 1'b1;
        end
    end

    assign ack_out      = ack_q | flag_q;
    assign stat.full    = req_seen & ~ack_q;
    assign stat.ack_reg = ack_q;
    assign stat.flag    = flag_q;

    // R2 / R9: once the sender lets go, the acknowledge falls at the next edge
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_out && !raw_req) |=> !ack_out);

    // R6: a held token is not acknowledged by the compute path
    p_token_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (raw_req && marked && !ack_out && !flag_set) |=> !ack_out);

    // R8: the flush rule acknowledges a presented word at the next edge
    p_flag_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_set && raw_req) |=> ack_out);

    // R3: a consumed operand is acknowledged at the next edge
    p_fire_ack_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> ack_out);

endmodule

// File: rtl/hsf_flush_ctl.sv
module hsf_flush_ctl
    import hsf_pkg::*;
#(
    parameter int unsigned N_IN = DEF_PORTS
) (
    input  logic [N_IN-1:0] raw_req,
    input  logic [N_IN-1:0] ack_reg,
    input  logic [N_IN-1:0] marked,
    output flush_kind_e     kind,
    output logic [N_IN-1:0] flag_set
);

    logic all_present;
    logic all_marked;
    logic any_marked;

    assign all_present = &(raw_req & ~ack_reg);
    assign all_marked  = &marked;
    assign any_marked  = |marked;

    always_comb begin
        kind = FL_NONE;
        if (all_present) begin
            if (all_marked)
                kind = FL_ALL;
            else if (any_marked)
                kind = FL_SOME;
        end
    end

    always_comb begin
        unique case (kind)
            FL_ALL:  flag_set = '1;
            FL_SOME: flag_set = ~marked;
            default: flag_set = '0;
        endcase
    end

endmodule

// File: rtl/hsf_out_port.sv
module hsf_out_port
    import hsf_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [WIDTH-1:0] result,
    input  logic             ack_in,
    output logic             req,
    output logic [WIDTH:0]   data,
    output logic             empty
);

    logic           req_q;
    logic [WIDTH:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            data_q <= '0;
        end else if (fire) begin
            req_q  <= 1'b1;
            data_q <= {1'b0, result};
        end else if (req_q && ack_in) begin
            req_q  <= 1'b0;
        end
    end

    assign req   = req_q;
    assign data  = data_q;
    assign empty = !req_q && !ack_in;

    // R4: result held until taken
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req_q && !ack_in) |=> (req_q && $stable(data_q)));

    // R4: request withdrawn one edge after the consumer acknowledges
    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (req_q && ack_in) |=> !req_q);

    // R3: results never carry the token marker
    p_mark_zero_r3: assert property (@(posedge clk) disable iff (rst)
        req_q |-> !data_q[WIDTH]);

    // R5: a new result only follows an idle acknowledge
    p_fire_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $past(!ack_in));

endmodule

// File: rtl/hsf_port_wrap.sv
module hsf_port_wrap
    import hsf_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned N_IN  = DEF_PORTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_IN-1:0]           in_req,
    input  logic [N_IN-1:0][WIDTH:0]  in_data,
    output logic [N_IN-1:0]           in_ack,
    output logic                      out_req,
    output logic [WIDTH:0]            out_data,
    input  logic                      out_ack
);

    localparam int unsigned WORD_W = WIDTH + 1;

    in_stat_t                    stat     [N_IN];
    logic [N_IN-1:0]             full_v;
    logic [N_IN-1:0]             ackreg_v;
    logic [N_IN-1:0]             flag_v;
    logic [N_IN-1:0]             marked_v;
    logic [N_IN-1:0]             flag_set;
    logic [N_IN-1:0][WIDTH-1:0]  payload;
    logic [WIDTH-1:0]            result;
    logic [WORD_W-1:0]           out_word;
    logic                        out_empty;
    logic                        fire;
    flush_kind_e                 kind;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        hsf_in_port #(.WIDTH(WIDTH)) u_in (
            .clk      (clk),
            .rst      (rst),
            .raw_req  (in_req[i]),
            .word     (in_data[i]),
            .fire     (fire),
            .flag_set (flag_set[i]),
            .ack_out  (in_ack[i]),
            .marked   (marked_v[i]),
            .payload  (payload[i]),
            .stat     (stat[i])
        );
        assign full_v[i]   = stat[i].full;
        assign ackreg_v[i] = stat[i].ack_reg;
        assign flag_v[i]   = stat[i].flag;
    end

    hsf_flush_ctl #(.N_IN(N_IN)) u_flush (
        .raw_req  (in_req),
        .ack_reg  (ackreg_v),
        .marked   (marked_v),
        .kind     (kind),
        .flag_set (flag_set)
    );

    // combining function: modular sum of all operands
    always_comb begin
        result = '0;
        for (int i = 0; i < N_IN; i++)
            result = result + payload[i];
    end

    assign fire = (&full_v) && out_empty;

    hsf_out_port #(.WIDTH(WIDTH)) u_out (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .result (result),
        .ack_in (out_ack),
        .req    (out_req),
        .data   (out_word),
        .empty  (out_empty)
    );

    assign out_data = out_word;

    // R10: no flush flag appears while some sender is idle
    p_no_partial_r10: assert property (@(posedge clk) disable iff (rst)
        (!(&in_req) && flag_v == '0) |=> (flag_v == '0));

    // R7: an all-token round acknowledges every port together
    p_all_tokens_r7: assert property (@(posedge clk) disable iff (rst)
        (kind == FL_ALL) |=> (&in_ack));

    // R7 / R8: a flush decision never starts a result
    p_flush_no_result_r7: assert property (@(posedge clk) disable iff (rst)
        (kind != FL_NONE && !out_req) |=> !out_req);

endmodule

// File: tb/hsf_port_wrap_tb.sv
`timescale 1ns/1ps
module hsf_port_wrap_tb;

    localparam int W   = 16;
    localparam int N   = 2;
    localparam int LEN = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      in_req = '0;
    logic [N-1:0][W:0] in_data = '0;
    logic [N-1:0]      in_ack;
    logic              out_req;
    logic [W:0]        out_data;
    logic              out_ack = 1'b0;

    always #10 clk = ~clk;

    hsf_port_wrap #(.WIDTH(W), .N_IN(N)) u_dut (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] wv [N][LEN];
    bit           wt [N][LEN];
    int           wlen [N];
    logic [W-1:0] exp_out [LEN];
    int           n_exp;
    int           exp_used [N];

    int sst [N];
    int sdly [N];
    int sidx [N];
    int acked [N];
    int cst, cdly, ocount;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // transaction model: each round of list heads is a sum, a joint flush or a discard
    task automatic build_model();
        int  idx [N];
        bit  ex, all_t, any_t;
        logic [W-1:0] s;
        for (int p = 0; p < N; p++) idx[p] = 0;
        n_exp = 0;
        while (1) begin
            ex = 0;
            for (int p = 0; p < N; p++) if (idx[p] >= wlen[p]) ex = 1;
            if (ex) break;
            all_t = 1; any_t = 0; s = '0;
            for (int p = 0; p < N; p++) begin
                all_t = all_t & wt[p][idx[p]];
                any_t = any_t | wt[p][idx[p]];
                s = s + wv[p][idx[p]];
            end
            if (!any_t) begin
                exp_out[n_exp] = s;
                n_exp++;
                for (int p = 0; p < N; p++) idx[p]++;
            end else if (all_t) begin
                for (int p = 0; p < N; p++) idx[p]++;
            end else begin
                for (int p = 0; p < N; p++) if (!wt[p][idx[p]]) idx[p]++;
            end
        end
        for (int p = 0; p < N; p++) exp_used[p] = idx[p];
    endtask

    task automatic step_agents();
        for (int p = 0; p < N; p++) begin
            case (sst[p])
                1: if (in_ack[p]) begin in_req[p] = 1'b0; acked[p]++; sst[p] = 2; end
                2: if (!in_ack[p]) begin sst[p] = 0; sdly[p] = $urandom_range(0, 3); end
                default: if (sidx[p] < wlen[p]) begin
                    if (sdly[p] == 0) begin
                        in_data[p] = {wt[p][sidx[p]], wv[p][sidx[p]]};
                        in_req[p]  = 1'b1;
                        sidx[p]++;
                        sst[p] = 1;
                    end else sdly[p]--;
                end
            endcase
        end
        if (cst == 0) begin
            if (out_req) begin
                if (cdly == 0) begin
                    if (ocount < n_exp)
                        check("R3 random result", {15'd0, out_data}, {15'd0, 1'b0, exp_out[ocount]});
                    else
                        check("R7/R8 unexpected result", 32'd1, 32'd0);
                    ocount++;
                    out_ack = 1'b1;
                    cst = 1;
                end else cdly--;
            end
        end else if (!out_req) begin
            out_ack = 1'b0;
            cst = 0;
            cdly = $urandom_range(0, 4);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_req = '0; out_ack = 1'b0;
        tick_n(2);
        rst = 1'b0;
        tick_n(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        int cyc;
        bit settled;
        seed_dummy = $urandom(32'h5eed);

        // R1: reset state
        tick_n(3);
        check("R1 in_ack under reset", {30'd0, in_ack}, 32'h3);
        check("R1 out_req under reset", {31'd0, out_req}, 32'd0);
        check("R1 out_data under reset", {15'd0, out_data}, 32'd0);
        rst = 1'b0;
        tick_n(1);
        check("R2 ack release after reset", {30'd0, in_ack}, 32'd0);

        // R6 / R10: lone token waits
        in_data[0] = {1'b1, 16'h1234}; in_req[0] = 1'b1;
        tick_n(5);
        check("R6 lone token not acked", {30'd0, in_ack}, 32'd0);
        check("R10 no output on lone token", {31'd0, out_req}, 32'd0);
        // R7: all tokens
        in_data[1] = {1'b1, 16'h0042}; in_req[1] = 1'b1;
        tick_n(1);
        check("R7 all tokens acked", {30'd0, in_ack}, 32'h3);
        check("R7 no result", {31'd0, out_req}, 32'd0);
        in_req = '0;
        tick_n(1);
        check("R9 flags cleared", {30'd0, in_ack}, 32'd0);

        // R8: token plus ordinary word
        in_data[0] = {1'b1, 16'h0000}; in_req[0] = 1'b1;
        in_data[1] = {1'b0, 16'h0777}; in_req[1] = 1'b1;
        tick_n(1);
        check("R8 ordinary discarded", {30'd0, in_ack}, 32'h2);
        check("R8 no result", {31'd0, out_req}, 32'd0);
        in_req[1] = 1'b0;
        tick_n(1);
        check("R9 discard ack drops", {30'd0, in_ack}, 32'd0);
        in_data[1] = {1'b1, 16'h0000}; in_req[1] = 1'b1;
        tick_n(1);
        check("R7 barrier completes", {30'd0, in_ack}, 32'h3);
        in_req = '0;
        tick_n(2);

        // R3: compute with wrap-around
        in_data[0] = {1'b0, 16'hFFFF}; in_data[1] = {1'b0, 16'h0002}; in_req = 2'b11;
        tick_n(1);
        check("R3 inputs acked", {30'd0, in_ack}, 32'h3);
        check("R3 out_req", {31'd0, out_req}, 32'd1);
        check("R3 sum wraps, marker 0", {15'd0, out_data}, 32'h00001);
        in_req = '0;
        tick_n(1);
        check("R2 ack released", {30'd0, in_ack}, 32'd0);
        // R5 / R4: output busy
        in_data[0] = {1'b0, 16'h1000}; in_data[1] = {1'b0, 16'h0234}; in_req = 2'b11;
        tick_n(4);
        check("R5 no fire while busy", {30'd0, in_ack}, 32'd0);
        check("R4 req held", {31'd0, out_req}, 32'd1);
        check("R4 data held", {15'd0, out_data}, 32'h00001);
        out_ack = 1'b1;
        tick_n(1);
        check("R4 req drops after ack", {31'd0, out_req}, 32'd0);
        tick_n(2);
        check("R5 no fire while ack high", {31'd0, out_req}, 32'd0);
        check("R5 inputs still waiting", {30'd0, in_ack}, 32'd0);
        out_ack = 1'b0;
        tick_n(1);
        check("R3 fires once empty", {31'd0, out_req}, 32'd1);
        check("R3 second sum", {15'd0, out_data}, 32'h01234);
        in_req = '0; out_ack = 1'b1;
        tick_n(1);
        out_ack = 1'b0;
        tick_n(2);

        // random rounds
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int p = 0; p < N; p++) begin
                wlen[p] = $urandom_range(8, LEN);
                for (int k = 0; k < LEN; k++) begin
                    wv[p][k] = W'($urandom);
                    wt[p][k] = ($urandom_range(0, 3) == 0);
                end
                sst[p] = 0; sdly[p] = 0; sidx[p] = 0; acked[p] = 0;
            end
            build_model();
            cst = 0; cdly = 0; ocount = 0;
            cyc = 0; settled = 0;
            while (cyc < 6000 && !settled) begin
                tick_n(1);
                step_agents();
                cyc++;
                settled = (ocount == n_exp) && (cst == 0);
                for (int p = 0; p < N; p++) if (acked[p] != exp_used[p]) settled = 0;
            end
            for (int i = 0; i < 30; i++) begin
                tick_n(1);
                step_agents();
            end
            check("R3 random result count", ocount, n_exp);
            for (int p = 0; p < N; p++)
                check("R8 random acked words", acked[p], exp_used[p]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule